// File: doc/BRIEF.md
# Configurable Logic Slice Carry Chain

This block models one logic slice with a lower and an upper half, each built from a 4-input lookup table, a carry-generate selector, a carry mux steered by the table output, a sum XOR and an output flip-flop. Slices are stacked into a vertical column. The carry out of each slice enters the slice above it, so the column behaves as one fast ripple path.

All configuration is static and set by parameters: the table contents, where each half takes its generated carry from, whether the outputs carry the table value or the sum, the flip-flop reset value, and whether the bottom slice starts its carry from the chain input or from its lower bypass pin. A single column can therefore serve as an adder, as a multiplier partial-product stage that uses the AND term, or as plain Boolean logic with a constant carry source.

The block has no state machine. Its only state is one flip-flop per half, and each flip-flop has two modes, load and hold, with a synchronous reset that takes priority.

Top module: `slice_carry_chain`

## Requirements
- R1: The table output of a half is bit k of LUT_INIT, where k = {pin4,pin3,pin2,pin1} and pin1 is the least significant bit.
- R2: The bottom slice starts its carry from the lower bypass input (bypass bit 0 of that slice) when BOTTOM_FROM_BYP is 1, and from chain_cin when it is 0. Higher slices always start from the carry out of the slice below.
- R3: A half's generated carry is selected by GEN_SRC: pin1, pin2, pin1 AND pin2, that half's own bypass input, constant 0 or constant 1. Bypass inputs that are not selected have no effect on any output.
- R4: The lower carry mux outputs the initial carry when the lower table output is 1, and the lower generated carry when it is 0.
- R5: The upper carry mux outputs the lower mux output when the upper table output is 1, and the upper generated carry when it is 0. Its output is the slice carry out.
- R6: The sum of a half is its table output XOR its incoming carry. With OUT_SUM set to 1, the combinational output is the sum. With OUT_SUM set to 0, it is the table output.
- R7: On a rising clock edge with ce high and rst low, a flip-flop captures its half's combinational output. With ce low, it holds its value.
- R8: With rst high at a rising edge, every flip-flop loads RST_VAL, whatever ce is.
- R9: With LUT_INIT = 16'h6666, GEN_SRC = pin1 and the bottom carry taken from the bypass input, N_SLICES slices add the 2*N_SLICES-bit operands on pin1 and pin2 plus that carry. comb_out carries the sum and chain_cout carries the carry out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output flip-flops |
| rst | input | 1 | Synchronous reset of the flip-flops to RST_VAL |
| ce | input | 1 | Clock enable of the flip-flops |
| lut_in | input | 8*N_SLICES | Table pins; half h of slice s uses bits [(2s+h)*4 +: 4], pin1 lowest |
| byp_in | input | 2*N_SLICES | Bypass inputs; bit 2s+h belongs to half h of slice s |
| chain_cin | input | 1 | Carry into the bottom slice from below |
| comb_out | output | 2*N_SLICES | Combinational result per half |
| reg_out | output | 2*N_SLICES | Registered result per half |
| chain_cout | output | 1 | Carry out of the top slice |

## Verification
A wrong carry selector or a wrong mux polarity appears in the same cycle on chain_cout and on the sum outputs of every half above the faulty point. For this reason every table input, bypass bit and carry-in value is swept exhaustively on single-slice columns for each carry source. A fault in the flip-flop enable or reset path shows on reg_out one edge later, and it persists until the next load. The stacked adder is compared against an arithmetic sum, so a broken link between slices corrupts the upper sum bits at once.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
    // source of the generated carry in one half
    typedef enum logic [2:0] {
        GEN_PIN1 = 3'd0,
        GEN_PIN2 = 3'd1,
        GEN_AND  = 3'd2,
        GEN_BYP  = 3'd3,
        GEN_ZERO = 3'd4,
        GEN_ONE  = 3'd5
    } gen_src_e;

    localparam int LUT_PINS = 4;
    localparam int LUT_BITS = 1 << LUT_PINS;
endpackage

// File: rtl/lcs_half.sv
module lcs_half
    import lcs_pkg::*;
#(
    parameter logic [LUT_BITS-1:0] LUT_INIT = 16'h6666,
    parameter gen_src_e            GEN_SRC  = GEN_BYP,
    parameter bit                  OUT_SUM  = 1'b1,
    parameter bit                  RST_VAL  = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic [LUT_PINS-1:0] pins,
    input  logic                byp,
    input  logic                c_in,
    output logic                lut_o,
    output logic                gen_o,
    output logic                c_next,
    output logic                comb_o,
    output logic                q
);
    logic sum;

    assign lut_o = LUT_INIT[pins];

    always_comb begin
        unique case (GEN_SRC)
            GEN_PIN1: gen_o = pins[0];
            GEN_PIN2: gen_o = pins[1];
            GEN_AND:  gen_o = pins[0] & pins[1];
            GEN_BYP:  gen_o = byp;
            GEN_ONE:  gen_o = 1'b1;
            default:  gen_o = 1'b0;
        endcase
    end

    assign c_next = lut_o ? c_in : gen_o;
    assign sum    = lut_o ^ c_in;

    generate
        if (OUT_SUM) begin : g_sum
            assign comb_o = sum;
        end else begin : g_lut
            assign comb_o = lut_o;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (ce)
            q <= comb_o;
    end

    // R7
    ff_load_chk: assert property (@(posedge clk) disable iff (rst)
        ce |=> q == $past(comb_o));

    // R7
    ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));

    // R8
    ff_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> q == RST_VAL);
endmodule

// File: rtl/lcs_slice.sv
module lcs_slice
    import lcs_pkg::*;
#(
    parameter logic [LUT_BITS-1:0] LUT_INIT      = 16'h6666,
    parameter gen_src_e            GEN_SRC       = GEN_BYP,
    parameter bit                  OUT_SUM       = 1'b1,
    parameter bit                  RST_VAL       = 1'b0,
    parameter bit                  INIT_FROM_BYP = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ce,
    input  logic [2*LUT_PINS-1:0] pins,
    input  logic [1:0]            byp,
    input  logic                  cin,
    output logic [1:0]            comb_o,
    output logic [1:0]            q,
    output logic                  cout
);
    logic       c_init;
    logic [1:0] lut_h, gen_h, c_h;
    logic [2:0] c_link;

    assign c_init    = INIT_FROM_BYP ? byp[0] : cin;
    assign c_link[0] = c_init;

    genvar h;
    generate
        for (h = 0; h < 2; h++) begin : g_half
            lcs_half #(
                .LUT_INIT (LUT_INIT),
                .GEN_SRC  (GEN_SRC),
                .OUT_SUM  (OUT_SUM),
                .RST_VAL  (RST_VAL)
            ) half_i (
                .clk    (clk),
                .rst    (rst),
                .ce     (ce),
                .pins   (pins[h*LUT_PINS +: LUT_PINS]),
                .byp    (byp[h]),
                .c_in   (c_link[h]),
                .lut_o  (lut_h[h]),
                .gen_o  (gen_h[h]),
                .c_next (c_h[h]),
                .comb_o (comb_o[h]),
                .q      (q[h])
            );
            assign c_link[h+1] = c_h[h];
        end
    endgenerate

    assign cout = c_link[2];

    // R4
    lo_gen_chk: assert property (@(posedge clk) disable iff (rst)
        !lut_h[0] |-> c_h[0] == gen_h[0]);

    // R5
    hi_gen_chk: assert property (@(posedge clk) disable iff (rst)
        !lut_h[1] |-> cout == gen_h[1]);

    // R5
    prop_thru_chk: assert property (@(posedge clk) disable iff (rst)
        (lut_h[0] && lut_h[1]) |-> cout == c_init);
endmodule

// File: rtl/slice_carry_chain.sv
module slice_carry_chain
    import lcs_pkg::*;
#(
    parameter int                  N_SLICES        = 4,
    parameter logic [LUT_BITS-1:0] LUT_INIT        = 16'h6666,
    parameter gen_src_e            GEN_SRC         = GEN_BYP,
    parameter bit                  OUT_SUM         = 1'b1,
    parameter bit                  RST_VAL         = 1'b0,
    parameter bit                  BOTTOM_FROM_BYP = 1'b0,
    localparam int                 N_HALVES        = 2 * N_SLICES,
    localparam int                 PIN_W           = N_HALVES * LUT_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic [PIN_W-1:0]    lut_in,
    input  logic [N_HALVES-1:0] byp_in,
    input  logic                chain_cin,
    output logic [N_HALVES-1:0] comb_out,
    output logic [N_HALVES-1:0] reg_out,
    output logic                chain_cout
);
    logic [N_SLICES:0] carry;

    assign carry[0] = chain_cin;

    genvar s;
    generate
        for (s = 0; s < N_SLICES; s++) begin : g_slice
            lcs_slice #(
                .LUT_INIT      (LUT_INIT),
                .GEN_SRC       (GEN_SRC),
                .OUT_SUM       (OUT_SUM),
                .RST_VAL       (RST_VAL),
                .INIT_FROM_BYP ((s == 0) ? BOTTOM_FROM_BYP : 1'b0)
            ) slice_i (
                .clk    (clk),
                .rst    (rst),
                .ce     (ce),
                .pins   (lut_in[s*2*LUT_PINS +: 2*LUT_PINS]),
                .byp    (byp_in[2*s +: 2]),
                .cin    (carry[s]),
                .comb_o (comb_out[2*s +: 2]),
                .q      (reg_out[2*s +: 2]),
                .cout   (carry[s+1])
            );
        end
    endgenerate

    assign chain_cout = carry[N_SLICES];
endmodule

// File: tb/slice_carry_chain_tb_top.sv
`timescale 1ns/1ps
module slice_carry_chain_tb_top;
    import lcs_pkg::*;

    localparam int NS = 4;
    localparam int NH = 2 * NS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce  = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // wide adder column
    logic [NH*4-1:0] a_pins = '0;
    logic [NH-1:0]   a_byp  = '0;
    logic            a_cin  = 1'b0;
    logic [NH-1:0]   a_comb, a_reg;
    logic            a_cout;

    slice_carry_chain #(
        .N_SLICES(NS), .LUT_INIT(16'h6666), .GEN_SRC(GEN_PIN1),
        .OUT_SUM(1'b1), .RST_VAL(1'b0), .BOTTOM_FROM_BYP(1'b1)
    ) dut_i (
        .clk(clk), .rst(rst), .ce(ce), .lut_in(a_pins), .byp_in(a_byp),
        .chain_cin(a_cin), .comb_out(a_comb), .reg_out(a_reg), .chain_cout(a_cout)
    );

    // single-slice columns sharing one stimulus
    localparam int NV = 6;
    localparam logic [15:0] V_INIT [NV] = '{16'hB38E, 16'h6A5C, 16'hF00F, 16'h19E7, 16'hC3A5, 16'h7E81};
    localparam gen_src_e    V_GEN  [NV] = '{GEN_AND, GEN_BYP, GEN_ONE, GEN_ZERO, GEN_PIN2, GEN_PIN1};
    localparam bit          V_SUM  [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam bit          V_RST  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam bit          V_FB   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    logic [7:0] s_pins = '0;
    logic [1:0] s_byp  = '0;
    logic       s_cin  = 1'b0;
    logic [1:0] s_comb [NV];
    logic [1:0] s_reg  [NV];
    logic       s_cout [NV];

    genvar g;
    generate
        for (g = 0; g < NV; g++) begin : g_var
            slice_carry_chain #(
                .N_SLICES(1), .LUT_INIT(V_INIT[g]), .GEN_SRC(V_GEN[g]),
                .OUT_SUM(V_SUM[g]), .RST_VAL(V_RST[g]), .BOTTOM_FROM_BYP(V_FB[g])
            ) var_i (
                .clk(clk), .rst(rst), .ce(ce), .lut_in(s_pins), .byp_in(s_byp),
                .chain_cin(s_cin), .comb_out(s_comb[g]), .reg_out(s_reg[g]),
                .chain_cout(s_cout[g])
            );
        end
    endgenerate

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit gen_of(gen_src_e gs, logic [3:0] p, logic b);
        case (gs)
            GEN_PIN1: return p[0];
            GEN_PIN2: return p[1];
            GEN_AND:  return p[0] & p[1];
            GEN_BYP:  return b;
            GEN_ONE:  return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    // returns {cout, comb[1], comb[0]}
    function automatic logic [2:0] model(int v, logic [7:0] p, logic [1:0] b, logic ci);
        logic l0, l1, c0, c1, cs;
        l0 = V_INIT[v][p[3:0]];
        l1 = V_INIT[v][p[7:4]];
        cs = V_FB[v] ? b[0] : ci;
        c0 = l0 ? cs : gen_of(V_GEN[v], p[3:0], b[0]);
        c1 = l1 ? c0 : gen_of(V_GEN[v], p[7:4], b[1]);
        if (V_SUM[v]) return {c1, l1 ^ c0, l0 ^ cs};
        return {c1, l1, l0};
    endfunction

    task automatic drive_add(input logic [NH-1:0] x, input logic [NH-1:0] y,
                             input logic ci, input logic [NH-1:0] junk);
        for (int k = 0; k < NH; k++)
            a_pins[k*4 +: 4] = {2'b00, y[k], x[k]};
        a_byp = {junk[NH-1:1], ci};
        a_cin = ~ci;   // chain input is unselected at the bottom
    endtask

    initial begin
        #(4ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NH:0] tot;
        logic [NH-1:0] x, y, jk, prev;
        logic ci;
        logic [2:0] e;

        repeat (3) @(negedge clk);
        // R8: reset values
        #1;
        check(a_reg == '0, "R8", a_reg, 0);
        for (int v = 0; v < NV; v++)
            check(s_reg[v] == {2{V_RST[v]}}, "R8", s_reg[v], {2{V_RST[v]}});

        @(negedge clk);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6: exhaustive single-slice sweep
        for (int n = 0; n < 2048; n++) begin
            @(negedge clk);
            s_pins = n[7:0];
            s_byp  = n[9:8];
            s_cin  = n[10];
            #1;
            for (int v = 0; v < NV; v++) begin
                e = model(v, s_pins, s_byp, s_cin);
                check({s_cout[v], s_comb[v]} == e, "R1 R2 R3 R4 R5 R6 slice",
                      {s_cout[v], s_comb[v]}, e);
            end
        end

        // R9 R2: adder column, corners then random
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            case (n)
                0: begin x = '1; y = '0; ci = 1'b1; end
                1: begin x = '1; y = '1; ci = 1'b1; end
                2: begin x = '0; y = '0; ci = 1'b0; end
                3: begin x = 8'hAA; y = 8'h55; ci = 1'b0; end
                default: begin x = NH'($urandom); y = NH'($urandom); ci = 1'($urandom); end
            endcase
            jk = NH'($urandom);
            drive_add(x, y, ci, jk);
            #1;
            tot = {1'b0, x} + {1'b0, y} + {{NH{1'b0}}, ci};
            check({a_cout, a_comb} == tot, "R9 adder", {a_cout, a_comb}, tot);
        end

        // R7: load with ce high
        @(negedge clk);
        drive_add(8'h3C, 8'h0F, 1'b1, '0);
        ce = 1'b1;
        #1;
        prev = a_comb;
        @(negedge clk);
        #1;
        check(a_reg == prev, "R7 load", a_reg, prev);
        for (int v = 0; v < NV; v++) begin
            e = model(v, s_pins, s_byp, s_cin);
            check(s_reg[v] == e[1:0], "R7 load slice", s_reg[v], e[1:0]);
        end

        // R7: hold with ce low while inputs change
        ce = 1'b0;
        drive_add(8'h01, 8'hFE, 1'b0, '1);
        s_pins = ~s_pins;
        repeat (2) @(negedge clk);
        #1;
        check(a_reg == prev, "R7 hold", a_reg, prev);
        check(a_comb == 8'hFF, "R9 hold inputs", a_comb, 8'hFF);

        // R8: reset wins over ce
        ce = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        #1;
        check(a_reg == '0, "R8 priority", a_reg, 0);
        for (int v = 0; v < NV; v++)
            check(s_reg[v] == {2{V_RST[v]}}, "R8 priority slice", s_reg[v], {2{V_RST[v]}});
        rst = 1'b0;
        ce  = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule